// File: doc/BRIEF.md
# 64b/66b Transmit Block Encoder

This block turns one eight-byte word from the media independent interface of a 40/100 Gb/s link into one 66-bit block for the physical coding sublayer. Each word has eight data bytes and eight control flags, one flag per byte. A word that carries only data becomes a data block: a two-bit sync header followed by the eight bytes unchanged. A word that holds control characters becomes a control block: a different sync header, then an 8-bit block type, then a payload whose layout depends on where the start, terminate or ordered-set character sits in the word.

The encoder assumes that ordered sets and packet starts always sit on an eight-byte boundary. So it only produces the start-in-lane-0 block and a single ordered-set block type. A separate block type for signal ordered sets can be switched on with a parameter. Any pattern the encoder cannot express becomes an error block. Scrambling, alignment markers and lane distribution belong to other blocks. The encoder puts out one block for each valid input word, exactly one clock later.

Top module: `xlg_tx_blk_enc`

## Requirements
- R1: Reset (rst_n low) clears out_valid. A word taken with in_valid high appears on out_block with out_valid high exactly one clock edge later.
- R2: A word with txc equal to 0 gives out_block[1:0] = 2'b01 and out_block[65:2] = txd. Byte i of the input is txd[8i+7:8i], and txc[i] flags that byte as a control character.
- R3: A word with all eight flags set, where every byte is idle (0x07) or error (0xFE), gives out_block[1:0] = 2'b10 and type out_block[9:2] = 0x1e. The 7-bit code for byte j sits at out_block[16+7j:10+7j]; idle encodes as 0x00 and error encodes as 0x1e.
- R4: txc = 0x01 with byte 0 equal to start (0xFB) gives header 2'b10 and type 0x78. Input bytes 1 to 7 are placed so that byte i sits at out_block[9+8i:2+8i].
- R5: txc = 0x01 with byte 0 equal to the sequence ordered-set character (0x9C) gives header 2'b10 and type 0x4b. Bytes 1 to 7 use the same placement as in R4, and no ordered-set code nibble is inserted.
- R6: txc = 0x01 with byte 0 equal to the signal ordered-set character (0x5C) gives type 0x55 with the R4 placement when parameter SIG_OS_EN is 1. When SIG_OS_EN is 0, the same word gives the error block of R8.
- R7: A terminate (0xFD) in byte k needs three things: txc[i] is 0 for every i < k, txc[i] is 1 for every i >= k, and every byte after k is idle or error. Such a word gives header 2'b10 with type 0x87, 0x99, 0xaa, 0xb4, 0xcc, 0xd2, 0xe1 or 0xff for k = 0 to 7. Data byte i < k sits at out_block[17+8i:10+8i]. The code of byte j > k sits at out_block[16+7j:10+7j], using the R3 codes. All other payload bits are 0.
- R8: Any other pattern with at least one flag set gives the error block: header 2'b10, type 0x1e, and all eight 7-bit codes equal to 0x1e. Examples are a start outside lane 0, an unknown control character, and a terminate followed by a byte that is not idle or error.
- R9: A clock edge with in_valid low drives out_valid low and leaves out_block unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| txd | input | 64 | Eight input bytes, byte 0 in the low bits |
| txc | input | 8 | Control flag per byte |
| out_valid | output | 1 | Output block valid |
| out_block | output | 66 | Encoded block, sync header in bits 1:0 |

## Verification
Two different data words check that data blocks copy txd exactly, including the byte order. A word of all idles and a word of mixed idle and error bytes tell the two 7-bit codes apart and show where each code sits. The terminate is swept through all eight positions, with data in front and alternating idle and error behind. This catches a wrong type value, a wrong data packing, a misplaced zero gap and a misplaced code. The illegal words are a start in lane 3, an unknown control byte, an idle alone in lane 0, a terminate followed by a start, and a mask with a hole in it. Each of these must give the error block. The signal ordered-set word is sent to an instance with the type enabled and to one with it disabled.

// File: rtl/xlg_enc_pkg.sv
package xlg_enc_pkg;

    localparam int unsigned LANES     = 8;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned CODE_W    = 7;
    localparam int unsigned HDR_W     = 2;
    localparam int unsigned TYPE_W    = 8;
    localparam int unsigned WORD_W    = LANES * BYTE_W;
    localparam int unsigned BLK_W     = HDR_W + WORD_W;
    localparam int unsigned POS_W     = $clog2(LANES);
    localparam int unsigned PLD_LO    = HDR_W + TYPE_W;

    localparam logic [BYTE_W-1:0] CH_IDLE  = 8'h07;
    localparam logic [BYTE_W-1:0] CH_START = 8'hFB;
    localparam logic [BYTE_W-1:0] CH_TERM  = 8'hFD;
    localparam logic [BYTE_W-1:0] CH_ERROR = 8'hFE;
    localparam logic [BYTE_W-1:0] CH_SEQ   = 8'h9C;
    localparam logic [BYTE_W-1:0] CH_SIG   = 8'h5C;

    localparam logic [CODE_W-1:0] CODE_IDLE  = 7'h00;
    localparam logic [CODE_W-1:0] CODE_ERROR = 7'h1e;

    localparam logic [HDR_W-1:0] HDR_DATA = 2'b01;
    localparam logic [HDR_W-1:0] HDR_CTRL = 2'b10;

    typedef enum logic [TYPE_W-1:0] {
        BT_ALLCTL = 8'h1e,
        BT_START  = 8'h78,
        BT_SEQOS  = 8'h4b,
        BT_SIGOS  = 8'h55,
        BT_TERM0  = 8'h87,
        BT_TERM1  = 8'h99,
        BT_TERM2  = 8'haa,
        BT_TERM3  = 8'hb4,
        BT_TERM4  = 8'hcc,
        BT_TERM5  = 8'hd2,
        BT_TERM6  = 8'he1,
        BT_TERM7  = 8'hff
    } blk_type_e;

    typedef struct packed {
        logic             vld;
        logic [BLK_W-1:0] blk;
    } enc_state_t;

    function automatic blk_type_e term_type(input logic [POS_W-1:0] pos);
        case (pos)
            3'd0:    term_type = BT_TERM0;
            3'd1:    term_type = BT_TERM1;
            3'd2:    term_type = BT_TERM2;
            3'd3:    term_type = BT_TERM3;
            3'd4:    term_type = BT_TERM4;
            3'd5:    term_type = BT_TERM5;
            3'd6:    term_type = BT_TERM6;
            default: term_type = BT_TERM7;
        endcase
    endfunction

endpackage

// File: rtl/xlg_lane_classify.sv
module xlg_lane_classify
    import xlg_enc_pkg::*;
(
    input  logic [BYTE_W-1:0] lane_byte,
    input  logic              lane_ctl,
    output logic [CODE_W-1:0] code7,
    output logic              ctl_ok,
    output logic              is_term
);

    always_comb begin
        code7   = CODE_ERROR;
        ctl_ok  = 1'b0;
        is_term = 1'b0;
        if (lane_ctl) begin
            case (lane_byte)
                CH_IDLE: begin
                    code7  = CODE_IDLE;
                    ctl_ok = 1'b1;
                end
                CH_ERROR: begin
                    code7  = CODE_ERROR;
                    ctl_ok = 1'b1;
                end
                CH_TERM: begin
                    is_term = 1'b1;
                end
                default: begin
                    code7 = CODE_ERROR;
                end
            endcase
        end
    end

endmodule

// File: rtl/xlg_term_locate.sv
module xlg_term_locate
    import xlg_enc_pkg::*;
(
    input  logic [LANES-1:0] txc,
    input  logic [LANES-1:0] is_term,
    input  logic [LANES-1:0] ctl_ok,
    output logic             term_hit,
    output logic [POS_W-1:0] term_pos
);

    logic [LANES-1:0] match;

    for (genvar k = 0; k < LANES; k++) begin : g_pos
        localparam logic [LANES-1:0] HI_MASK   = LANES'({LANES{1'b1}} << k);
        localparam logic [LANES-1:0] TAIL_MASK = LANES'(HI_MASK << 1);
        assign match[k] = (txc == HI_MASK) && is_term[k]
                          && ((ctl_ok & TAIL_MASK) == TAIL_MASK);
    end

    always_comb begin
        term_hit = |match;
        term_pos = '0;
        for (int k = 0; k < LANES; k++) begin
            if (match[k]) begin
                term_pos = POS_W'(k);
            end
        end
    end

endmodule

// File: rtl/xlg_blk_format.sv
module xlg_blk_format
    import xlg_enc_pkg::*;
#(
    parameter bit SIG_OS_EN = 1'b1
) (
    input  logic [WORD_W-1:0]       txd,
    input  logic [LANES-1:0]        txc,
    input  logic [LANES*CODE_W-1:0] codes,
    input  logic [LANES-1:0]        ctl_ok,
    input  logic                    term_hit,
    input  logic [POS_W-1:0]        term_pos,
    output logic [BLK_W-1:0]        blk
);

    localparam logic [LANES-1:0] LEAD_ONLY = LANES'(1);

    logic                    lead_ctl;
    logic [WORD_W-BYTE_W-1:0] tail_bytes;
    logic [LANES*CODE_W-1:0] err_codes;
    logic [LANES*CODE_W-1:0] term_pld;

    assign lead_ctl   = (txc == LEAD_ONLY);
    assign tail_bytes = txd[WORD_W-1:BYTE_W];
    assign err_codes  = {LANES{CODE_ERROR}};

    always_comb begin
        term_pld = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(term_pos)) begin
                term_pld[BYTE_W*i +: BYTE_W] = txd[BYTE_W*i +: BYTE_W];
            end
        end
        for (int j = 0; j < LANES; j++) begin
            if (j > int'(term_pos)) begin
                term_pld[CODE_W*j +: CODE_W] = codes[CODE_W*j +: CODE_W];
            end
        end
    end

    always_comb begin
        if (txc == '0) begin
            blk = {txd, HDR_DATA};
        end else if ((&txc) && (&ctl_ok)) begin
            blk = {codes, BT_ALLCTL, HDR_CTRL};
        end else if (lead_ctl && txd[BYTE_W-1:0] == CH_START) begin
            blk = {tail_bytes, BT_START, HDR_CTRL};
        end else if (lead_ctl && txd[BYTE_W-1:0] == CH_SEQ) begin
            blk = {tail_bytes, BT_SEQOS, HDR_CTRL};
        end else if (SIG_OS_EN && lead_ctl && txd[BYTE_W-1:0] == CH_SIG) begin
            blk = {tail_bytes, BT_SIGOS, HDR_CTRL};
        end else if (term_hit) begin
            blk = {term_pld, term_type(term_pos), HDR_CTRL};
        end else begin
            blk = {err_codes, BT_ALLCTL, HDR_CTRL};
        end
    end

endmodule

// File: rtl/xlg_tx_blk_enc.sv
module xlg_tx_blk_enc
    import xlg_enc_pkg::*;
#(
    parameter bit SIG_OS_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] txd,
    input  logic [LANES-1:0]  txc,
    output logic              out_valid,
    output logic [BLK_W-1:0]  out_block
);

    logic [LANES*CODE_W-1:0] codes;
    logic [LANES-1:0]        ctl_ok;
    logic [LANES-1:0]        is_term;
    logic                    term_hit;
    logic [POS_W-1:0]        term_pos;
    logic [BLK_W-1:0]        blk_next;
    enc_state_t              st_d;
    enc_state_t              st_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        xlg_lane_classify u_cls (
            .lane_byte (txd[BYTE_W*l +: BYTE_W]),
            .lane_ctl  (txc[l]),
            .code7     (codes[CODE_W*l +: CODE_W]),
            .ctl_ok    (ctl_ok[l]),
            .is_term   (is_term[l])
        );
    end

    xlg_term_locate u_loc (
        .txc      (txc),
        .is_term  (is_term),
        .ctl_ok   (ctl_ok),
        .term_hit (term_hit),
        .term_pos (term_pos)
    );

    xlg_blk_format #(
        .SIG_OS_EN (SIG_OS_EN)
    ) u_fmt (
        .txd      (txd),
        .txc      (txc),
        .codes    (codes),
        .ctl_ok   (ctl_ok),
        .term_hit (term_hit),
        .term_pos (term_pos),
        .blk      (blk_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.blk = blk_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_block = st_q.blk;

endmodule

// File: rtl/xlg_enc_checker.sv
module xlg_enc_checker
    import xlg_enc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] txd,
    input logic [LANES-1:0]  txc,
    input logic              out_valid,
    input logic [BLK_W-1:0]  out_block
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                              // R1

    AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_block)));                    // R9

    AST_DATA_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && txc == '0) |=> (out_block == {$past(txd), HDR_DATA}));  // R2

    AST_CTRL_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && txc != '0) |=> (out_block[1:0] == HDR_CTRL));           // R8

    AST_START_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && txc == 8'h01 && txd[7:0] == CH_START)
        |=> (out_block[9:2] == 8'h78 && out_block[65:10] == $past(txd[63:8]))); // R4

    AST_SEQ_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && txc == 8'h01 && txd[7:0] == CH_SEQ)
        |=> (out_block[9:2] == 8'h4b && out_block[65:10] == $past(txd[63:8]))); // R5

    AST_HDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_block[1:0] == HDR_DATA || out_block[1:0] == HDR_CTRL)); // R1

endmodule

bind xlg_tx_blk_enc xlg_enc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .txd       (txd),
    .txc       (txc),
    .out_valid (out_valid),
    .out_block (out_block)
);

// File: tb/test_xlg_tx_blk_enc.sv
`timescale 1ns/1ps
module test_xlg_tx_blk_enc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] txd = '0;
    logic [7:0]  txc = '0;
    logic        out_valid, out_valid_n;
    logic [65:0] out_block, out_block_n;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    xlg_tx_blk_enc #(.SIG_OS_EN(1'b1)) i_xlg_tx_blk_enc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .txd(txd), .txc(txc),
        .out_valid(out_valid), .out_block(out_block));

    xlg_tx_blk_enc #(.SIG_OS_EN(1'b0)) i_xlg_tx_blk_enc_nosig (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .txd(txd), .txc(txc),
        .out_valid(out_valid_n), .out_block(out_block_n));

    localparam logic [65:0] ERR_BLK = {{8{7'h1e}}, 8'h1e, 2'b10};

    task automatic check(input string req, input logic [65:0] act, input logic [65:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input logic [63:0] d, input logic [7:0] c);
        @(negedge clk);
        txd = d; txc = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", 66'(out_valid), 66'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_data();
        logic [63:0] w [2] = '{64'h0123_4567_89ab_cdef, 64'hfe07_fdfb_9c5c_0000};
        foreach (w[i]) begin
            push(w[i], 8'h00);
            check("R1 valid after word", 66'(out_valid), 66'd1);
            check("R2 data block", out_block, {w[i], 2'b01});
        end
    endtask

    task automatic t_all_ctrl();
        logic [63:0] d;
        logic [55:0] cd;
        push({8{8'h07}}, 8'hFF);
        check("R3 all idle", out_block, {56'd0, 8'h1e, 2'b10});
        d = '0; cd = '0;
        for (int j = 0; j < 8; j++) begin
            d[8*j +: 8]  = (j % 3 == 1) ? 8'hFE : 8'h07;
            cd[7*j +: 7] = (j % 3 == 1) ? 7'h1e : 7'h00;
        end
        push(d, 8'hFF);
        check("R3 idle error mix", out_block, {cd, 8'h1e, 2'b10});
    endtask

    task automatic t_start();
        push(64'h1122_3344_5566_77FB, 8'h01);
        check("R4 start lane0", out_block, {56'h1122_3344_5566_77, 8'h78, 2'b10});
    endtask

    task automatic t_seq();
        push(64'h0000_0000_0201_009C, 8'h01);
        check("R5 sequence os", out_block, {56'h0000_0000_0201_00, 8'h4b, 2'b10});
    endtask

    task automatic t_sig();
        push(64'hA1B2_C3D4_E5F6_075C, 8'h01);
        check("R6 signal os enabled", out_block, {56'hA1B2_C3D4_E5F6_07, 8'h55, 2'b10});
        check("R6 signal os disabled", out_block_n, ERR_BLK);
    endtask

    task automatic t_term();
        logic [7:0] types [8] = '{8'h87, 8'h99, 8'haa, 8'hb4, 8'hcc, 8'hd2, 8'he1, 8'hff};
        for (int k = 0; k < 8; k++) begin
            logic [63:0] d;
            logic [7:0]  c;
            logic [55:0] p;
            d = '0; c = '0; p = '0;
            for (int i = 0; i < 8; i++) begin
                if (i < k) begin
                    d[8*i +: 8] = 8'(8'h30 + 8'(i) * 8'h11);
                    p[8*i +: 8] = 8'(8'h30 + 8'(i) * 8'h11);
                end else if (i == k) begin
                    d[8*i +: 8] = 8'hFD;
                    c[i] = 1'b1;
                end else begin
                    d[8*i +: 8] = (i % 2 == 1) ? 8'hFE : 8'h07;
                    c[i] = 1'b1;
                    p[7*i +: 7] = (i % 2 == 1) ? 7'h1e : 7'h00;
                end
            end
            push(d, c);
            check($sformatf("R7 terminate lane %0d", k), out_block, {p, types[k], 2'b10});
        end
    endtask

    task automatic t_errors();
        push(64'h0000_0000_FB00_0000, 8'h08);
        check("R8 start lane3", out_block, ERR_BLK);
        push({8'h07, 8'h07, 8'h07, 8'h33, 8'h07, 8'h07, 8'h07, 8'h07}, 8'hFF);
        check("R8 unknown control", out_block, ERR_BLK);
        push(64'h1111_1111_1111_1107, 8'h01);
        check("R8 lone idle lane0", out_block, ERR_BLK);
        push({8'h07, 8'h07, 8'hFB, 8'h07, 8'h07, 8'hFD, 8'h55, 8'h66}, 8'hFC);
        check("R8 start after terminate", out_block, ERR_BLK);
        push({8'h07, 8'h07, 8'h07, 8'h07, 8'h44, 8'hFD, 8'h55, 8'h66}, 8'hEC);
        check("R8 hole in mask", out_block, ERR_BLK);
    endtask

    task automatic t_hold();
        logic [65:0] prev;
        push(64'hDEAD_BEEF_CAFE_F00D, 8'h00);
        prev = out_block;
        txd = '1; txc = 8'hFF;
        @(negedge clk);
        check("R9 valid low", 66'(out_valid), 66'd0);
        check("R9 block held", out_block, prev);
        @(negedge clk);
        check("R9 block still held", out_block, prev);
    endtask

    initial begin
        t_reset();
        t_data();
        t_all_ctrl();
        t_start();
        t_seq();
        t_sig();
        t_term();
        t_errors();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule